// File: doc/BRIEF.md
# Transmit Control-Code Character Sequencer

This block feeds an 8b/10b encoder on one serial-link transmit lane. On every character clock it takes a data byte, a two-bit control code, an odd-parity bit and a burst-mode select. From these it forms one registered character request for the encoder: a byte together with a flag that marks it as a special (K) character. The request can carry a data character, a special character, a K28.5 idle filler, or one step of a sixteen-character K28.5 alignment burst.

The alignment burst is started by control code 11. A mode input chooses how the burst behaves. In locked mode it always runs to its end and ignores the inputs. In breakable mode it runs on only while code 00 is presented, and any other code ends it at once. A violation symbol is not a separate input: the host presents byte 0xE0 with the special code. When parity checking is enabled, the block reports a parity error alongside the character it belongs to. The error never changes which character goes out.

Top module: `txCharSequencer`

## Requirements
- R1: With no burst tail pending, control code 00 produces `charOut` equal to the sampled byte with `charIsK` low.
- R2: With no burst tail pending, code 01 produces the filler byte 0xBC with `charIsK` high, whatever the data byte is.
- R3: With no burst tail pending, code 10 produces the sampled byte with `charIsK` high. Byte 0xE0 sent this way is the violation symbol.
- R4: With no burst tail pending, code 11 produces 0xBC/K, raises `syncActive` and sets `syncCount` to 0. An undisturbed burst shows counts 0 through 15 on 16 consecutive characters, all 0xBC/K. On the character after count 15 the inputs are decoded afresh, and a new code 11 there starts a new burst at count 0.
- R5: With `lockedMode` high during the tail (counts 1 to 15), every character is 0xBC/K and the count rises by one each clock. Data, control and parity inputs have no effect, and `parityErr` stays low.
- R6: With `lockedMode` low, a tail step continues only when code 00 is sampled. Any other code ends the burst in that cycle, and the character is formed from that cycle's inputs as in R2, R3 and R4 (code 11 restarts at count 0, and the others leave `syncActive` low).
- R7: With `parEnable` high and the inputs decoded, `parityErr` is high exactly when the nine bits {data byte, `parIn`} hold an even number of ones. It appears together with the character it belongs to and does not alter that character.
- R8: With `parEnable` low, `parityErr` stays low for any value of `parIn`.
- R9: While synchronous active-high `rst` is sampled high, the outputs become 0xBC/K with `charValid` low, `syncActive` low, `syncCount` 0 and `parityErr` low.
- R10: Every output is registered. Inputs sampled at a rising edge show up just after that edge, and `charValid` is high on every clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 8 | Byte to transmit |
| ctrlIn | input | 2 | Control code: 00 data, 01 filler, 10 special, 11 alignment burst |
| parIn | input | 1 | Odd-parity bit for `dataIn` |
| parEnable | input | 1 | Enables the parity check |
| lockedMode | input | 1 | 1: burst cannot be broken; 0: burst breaks on any code other than 00 |
| charOut | output | 8 | Character byte for the encoder |
| charIsK | output | 1 | Marks `charOut` as a special character |
| charValid | output | 1 | A character is presented this clock |
| syncActive | output | 1 | Current character belongs to an alignment burst |
| syncCount | output | 4 | Position of the current burst character, 0 to 15 |
| parityErr | output | 1 | Parity mismatch on the inputs that formed this character |

## Verification
Two functions can land on the same character. One is a parity error. The other is a change in burst state: a burst start, a break of a breakable burst by a special code, or a restart by code 11. The bench provokes this by presenting bad parity on exactly those cycles. It expects the error flag next to an unchanged character: a filler at count 0, or the special byte with the burst ended. A locked tail fed bad parity and hostile codes must show neither an error nor a change of character. A burst that ends at count 15 and is followed at once by code 11 checks that the new burst is not merged into the old one.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  typedef enum logic [1:0] {
    CODE_DATA    = 2'b00,
    CODE_FILL    = 2'b01,
    CODE_SPECIAL = 2'b10,
    CODE_SYNC    = 2'b11
  } ctrlCode_t;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic sendFill;     // emit the filler byte as K
    logic sendSpecial;  // emit the input byte as K
    logic checkParity;  // inputs are decoded and parity is checked
  } seqStrobe_t;

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl #(
  parameter int SYNC_LEN = 16,
  localparam int CNT_W = $clog2(SYNC_LEN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              ctrlIn,
  input  logic                    lockedMode,
  input  logic                    parEnable,
  output txseq_pkg::seqStrobe_t   strobe,
  output logic [CNT_W-1:0]        syncCount,
  output logic                    syncActive
);
  import txseq_pkg::*;

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SYNC_LEN - 1);

  ctrlCode_t        code;
  logic             tailOpen;
  logic             holdBurst;
  logic [CNT_W-1:0] nextCount;
  logic             nextActive;

  assign code      = ctrlCode_t'(ctrlIn);
  assign tailOpen  = syncActive && (syncCount != LAST_IDX);
  assign holdBurst = tailOpen && (lockedMode || code == CODE_DATA);

  always_comb begin
    strobe      = '{sendFill: 1'b0, sendSpecial: 1'b0, checkParity: parEnable};
    nextCount   = '0;
    nextActive  = 1'b0;
    if (holdBurst) begin
      strobe.sendFill    = 1'b1;
      strobe.checkParity = 1'b0;
      nextCount          = syncCount + 1'b1;
      nextActive         = 1'b1;
    end else begin
      unique case (code)
        CODE_DATA:    ;
        CODE_FILL:    strobe.sendFill = 1'b1;
        CODE_SPECIAL: strobe.sendSpecial = 1'b1;
        CODE_SYNC: begin
          strobe.sendFill = 1'b1;
          nextActive      = 1'b1;
        end
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncCount  <= '0;
      syncActive <= 1'b0;
    end else begin
      syncCount  <= nextCount;
      syncActive <= nextActive;
    end
  end

endmodule

// File: rtl/txseq_dpath.sv
module txseq_dpath #(
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] FILL_BYTE = 8'hBC,
  parameter bit               ODD_PARITY = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic                  parIn,
  input  txseq_pkg::seqStrobe_t strobe,
  output logic [DATA_W-1:0]     charOut,
  output logic                  charIsK,
  output logic                  charValid,
  output logic                  parityErr
);

  logic              parityBad;
  logic [DATA_W-1:0] nextChar;
  logic              nextK;

  generate
    if (ODD_PARITY) begin : g_odd
      assign parityBad = ~(^{dataIn, parIn});
    end else begin : g_even
      assign parityBad = ^{dataIn, parIn};
    end
  endgenerate

  always_comb begin
    nextChar = dataIn;
    nextK    = strobe.sendSpecial;
    if (strobe.sendFill) begin
      nextChar = FILL_BYTE;
      nextK    = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      charOut   <= FILL_BYTE;
      charIsK   <= 1'b1;
      charValid <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      charOut   <= nextChar;
      charIsK   <= nextK;
      charValid <= 1'b1;
      parityErr <= strobe.checkParity && parityBad;
    end
  end

endmodule

// File: rtl/txCharSequencer.sv
module txCharSequencer #(
  parameter int                DATA_W    = 8,
  parameter int                SYNC_LEN  = 16,
  parameter logic [DATA_W-1:0] FILL_BYTE = 8'hBC,
  localparam int               CNT_W     = $clog2(SYNC_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        ctrlIn,
  input  logic              parIn,
  input  logic              parEnable,
  input  logic              lockedMode,
  output logic [DATA_W-1:0] charOut,
  output logic              charIsK,
  output logic              charValid,
  output logic              syncActive,
  output logic [CNT_W-1:0]  syncCount,
  output logic              parityErr
);

  txseq_pkg::seqStrobe_t strobe;

  txseq_ctrl #(.SYNC_LEN(SYNC_LEN)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrlIn     (ctrlIn),
    .lockedMode (lockedMode),
    .parEnable  (parEnable),
    .strobe     (strobe),
    .syncCount  (syncCount),
    .syncActive (syncActive)
  );

  txseq_dpath #(.DATA_W(DATA_W), .FILL_BYTE(FILL_BYTE), .ODD_PARITY(1'b1)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .dataIn    (dataIn),
    .parIn     (parIn),
    .strobe    (strobe),
    .charOut   (charOut),
    .charIsK   (charIsK),
    .charValid (charValid),
    .parityErr (parityErr)
  );

endmodule

// File: rtl/txseq_checker.sv
module txseq_checker #(
  parameter int                DATA_W    = 8,
  parameter int                SYNC_LEN  = 16,
  parameter logic [DATA_W-1:0] FILL_BYTE = 8'hBC,
  localparam int               CNT_W     = $clog2(SYNC_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dataIn,
  input logic [1:0]        ctrlIn,
  input logic              parIn,
  input logic              parEnable,
  input logic              lockedMode,
  input logic [DATA_W-1:0] charOut,
  input logic              charIsK,
  input logic              charValid,
  input logic              syncActive,
  input logic [CNT_W-1:0]  syncCount,
  input logic              parityErr
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SYNC_LEN - 1);

  logic decodeNow;
  assign decodeNow = !syncActive || (syncCount == LAST_IDX);

  assert_data_char_R1: assert property (@(posedge clk) disable iff (rst)
    (decodeNow && ctrlIn == 2'b00) |=> (charOut == $past(dataIn) && !charIsK && !syncActive));

  assert_fill_char_R2: assert property (@(posedge clk) disable iff (rst)
    (decodeNow && ctrlIn == 2'b01) |=> (charOut == FILL_BYTE && charIsK && !syncActive));

  assert_special_char_R3: assert property (@(posedge clk) disable iff (rst)
    (decodeNow && ctrlIn == 2'b10) |=> (charOut == $past(dataIn) && charIsK && !syncActive));

  assert_burst_start_R4: assert property (@(posedge clk) disable iff (rst)
    (decodeNow && ctrlIn == 2'b11) |=> (syncActive && syncCount == '0 && charOut == FILL_BYTE && charIsK));

  assert_locked_tail_R5: assert property (@(posedge clk) disable iff (rst)
    (!decodeNow && lockedMode) |=>
      (syncActive && syncCount == $past(syncCount) + 1'b1 && charOut == FILL_BYTE && charIsK && !parityErr));

  assert_break_special_R6: assert property (@(posedge clk) disable iff (rst)
    (!decodeNow && !lockedMode && ctrlIn == 2'b10) |=> (!syncActive && charOut == $past(dataIn) && charIsK));

  assert_break_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (!decodeNow && !lockedMode && ctrlIn == 2'b11) |=> (syncActive && syncCount == '0));

  assert_parity_off_R8: assert property (@(posedge clk) disable iff (rst)
    !parEnable |=> !parityErr);

  assert_valid_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> charValid);

endmodule

bind txCharSequencer txseq_checker #(
  .DATA_W(DATA_W), .SYNC_LEN(SYNC_LEN), .FILL_BYTE(FILL_BYTE)
) i_chk (.*);

// File: tb/test_txCharSequencer.sv
`timescale 1ns/1ps
module test_txCharSequencer;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] dataIn;
  logic [1:0] ctrlIn;
  logic       parIn;
  logic       parEnable;
  logic       lockedMode;
  logic [7:0] charOut;
  logic       charIsK;
  logic       charValid;
  logic       syncActive;
  logic [3:0] syncCount;
  logic       parityErr;

  int checks = 0;
  int errors = 0;

  // reference model state: burst index, -1 when idle
  int mIdx;
  int expChar, expK, expValid, expActive, expCount, expErr;

  always #2.5 clk = ~clk;

  txCharSequencer i_txCharSequencer (
    .clk(clk), .rst(rst), .dataIn(dataIn), .ctrlIn(ctrlIn), .parIn(parIn),
    .parEnable(parEnable), .lockedMode(lockedMode), .charOut(charOut),
    .charIsK(charIsK), .charValid(charValid), .syncActive(syncActive),
    .syncCount(syncCount), .parityErr(parityErr)
  );

  function automatic bit goodPar(input logic [7:0] d);
    return ($countones(d) % 2) == 0;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (charOut !== 8'(expChar) || charIsK !== 1'(expK) || charValid !== 1'(expValid) ||
        syncActive !== 1'(expActive) || syncCount !== 4'(expCount) || parityErr !== 1'(expErr)) begin
      errors++;
      $display("FAIL %s actual char=%02h k=%0b v=%0b act=%0b cnt=%0d err=%0b expected char=%02h k=%0d v=%0d act=%0d cnt=%0d err=%0d",
               tag, charOut, charIsK, charValid, syncActive, syncCount, parityErr,
               expChar, expK, expValid, expActive, expCount, expErr);
    end
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1;
    mIdx = -1;
    expChar = 8'hBC; expK = 1; expValid = 0; expActive = 0; expCount = 0; expErr = 0;
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic step(input logic [7:0] d, input logic [1:0] c, input logic p,
                      input logic pe, input logic lk, input string tag);
    int ones;
    rst = 1'b0; dataIn = d; ctrlIn = c; parIn = p; parEnable = pe; lockedMode = lk;
    expValid = 1;
    if (mIdx >= 0 && mIdx < 15 && (lk || c == 2'b00)) begin
      mIdx++;
      expChar = 8'hBC; expK = 1; expErr = 0;
    end else begin
      ones = $countones(d) + int'(p);
      expErr = (pe && (ones % 2 == 0)) ? 1 : 0;
      case (c)
        2'b00: begin expChar = d;     expK = 0; mIdx = -1; end
        2'b01: begin expChar = 8'hBC; expK = 1; mIdx = -1; end
        2'b10: begin expChar = d;     expK = 1; mIdx = -1; end
        default: begin expChar = 8'hBC; expK = 1; mIdx = 0; end
      endcase
    end
    expActive = (mIdx >= 0) ? 1 : 0;
    expCount  = (mIdx >= 0) ? mIdx : 0;
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dataIn = 8'h00; ctrlIn = 2'b00; parIn = 1'b1; parEnable = 1'b0; lockedMode = 1'b1;
    #1;
    doReset("R9");
    doReset("R9");

    // plain codes
    step(8'h3C, 2'b00, goodPar(8'h3C), 1, 0, "R1");
    step(8'hA5, 2'b00, goodPar(8'hA5), 1, 0, "R10");
    step(8'h77, 2'b01, goodPar(8'h77), 1, 0, "R2");
    step(8'h1C, 2'b10, goodPar(8'h1C), 1, 0, "R3");
    step(8'hE0, 2'b10, goodPar(8'hE0), 1, 0, "R3");

    // parity
    step(8'h01, 2'b00, 1'b1, 1, 0, "R7");
    step(8'hF0, 2'b10, ~goodPar(8'hF0), 1, 0, "R7");
    step(8'h81, 2'b01, 1'b1, 1, 0, "R7");
    step(8'h01, 2'b00, 1'b1, 0, 0, "R8");
    step(8'h00, 2'b10, 1'b0, 0, 0, "R8");

    // locked burst with hostile inputs, then back-to-back burst
    step(8'h55, 2'b11, goodPar(8'h55), 1, 1, "R4");
    for (int i = 1; i < 16; i++)
      step(8'(i * 37), (i % 2) ? 2'b10 : 2'b11, ~goodPar(8'(i * 37)), 1, 1, "R5");
    step(8'h66, 2'b11, ~goodPar(8'h66), 1, 1, "R4");
    for (int i = 1; i < 16; i++)
      step(8'h00, 2'b00, 1'b1, 1, 1, "R4");
    step(8'h42, 2'b00, goodPar(8'h42), 1, 1, "R4");

    // breakable burst: continue on 00, break with special plus parity error
    step(8'h10, 2'b11, goodPar(8'h10), 1, 0, "R4");
    for (int i = 0; i < 4; i++)
      step(8'(i), 2'b00, ~goodPar(8'(i)), 1, 0, "R6");
    step(8'hE0, 2'b10, ~goodPar(8'hE0), 1, 0, "R6");
    step(8'h99, 2'b00, goodPar(8'h99), 1, 0, "R1");

    // breakable burst broken by restart, then by filler
    step(8'h20, 2'b11, goodPar(8'h20), 1, 0, "R4");
    step(8'h00, 2'b00, goodPar(8'h00), 1, 0, "R6");
    step(8'h33, 2'b11, ~goodPar(8'h33), 1, 0, "R6");
    step(8'h00, 2'b00, goodPar(8'h00), 1, 0, "R6");
    step(8'h44, 2'b01, goodPar(8'h44), 1, 0, "R6");

    // breakable burst run to completion
    step(8'h00, 2'b11, goodPar(8'h00), 0, 0, "R4");
    for (int i = 1; i < 16; i++)
      step(8'h00, 2'b00, 1'b0, 0, 0, "R6");
    step(8'hC3, 2'b10, goodPar(8'hC3), 0, 0, "R3");

    // reset mid-burst
    step(8'h00, 2'b11, goodPar(8'h00), 1, 1, "R4");
    doReset("R9");
    step(8'h5A, 2'b00, goodPar(8'h5A), 1, 1, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule